// File: doc/BRIEF.md
# Multiplexed Serial Link Transceiver

A hub serves sixteen serial link lines with one shift engine. Every line has a half-duplex DATA wire and a wired-AND SYNCH wire: each end holds SYNCH low until it is ready, and a bit moves only when both ends have let go. The hub writes a command byte that names a line and an operation. The block then routes that line's DATA and SYNCH to its shift register through a multiplexer and a demultiplexer. It sends or receives one 8-bit word, most significant bit first, and reports completion in a status byte.

Each line has a SYNCH release flip-flop. An enable demultiplexer sets it and a disable demultiplexer clears it. At reset and while a line is idle, the flip-flop is clear and the hub clamps that line's SYNCH low. In the keep mode the flip-flop stays set after a transfer, so two remote endpoints can go on talking through the switch. A rising edge on a line's remote request input clears that line's flip-flop in hardware, because the controlling processor may react too slowly.

The controller has five states. IDLE (code 000) accepts commands. WRITE (001) shifts out a word. READ (110) shifts in a word. DONE (100) raises ready and the interrupt, and waits for a clear command. END (011) drops the SYNCH release and returns to IDLE. The transitions are:
- IDLE to WRITE when a send command is accepted.
- IDLE to READ when a receive command is accepted.
- WRITE or READ to DONE on the eighth transferred bit.
- DONE to END on a clear command in the normal mode.
- DONE to IDLE on a clear command in the keep mode.
- END to IDLE on the next cycle, without condition.

Top module: `xcvr_mux_hub`

## Requirements
- R1: After reset the state code is 000, no line's SYNCH is released, no DATA output is enabled, the status byte is 0x00, irq is low and rx_word is 0x00.
- R2: state_code shows IDLE=000, WRITE=001, READ=110, DONE=100 and END=011.
- R3: The command fields are as follows. Bits 3..0 give the line, bit 4 asks for a receive, bit 5 asks for a send (send wins when both are set), bit 6 selects the keep mode and bit 7 is the clear. In IDLE, a command with bits 5 and 4 both zero only loads the line number (status[3:0]) and stays in IDLE.
- R4: An accepted send sets the selected line's SYNCH release. It drives that line's DATA most significant bit first, one bit per cycle in which that line's SYNCH is high, and it enables only that line's DATA output.
- R5: An accepted receive releases the line's SYNCH. It samples that line's DATA at each clock edge where SYNCH is high, most significant bit first, and presents the 8-bit word on rx_word once the eighth bit is in.
- R6: While the selected line's SYNCH is low, no bit moves: the presented bit and the bit position are held.
- R7: After the eighth bit the state is DONE, status[7] (ready) and irq are high, and DONE holds until a command with bit 7 set arrives.
- R8: A clear in the normal mode passes through END for one cycle and then reaches IDLE with the line's SYNCH release dropped.
- R9: A clear in the keep mode returns straight to IDLE and leaves the line's SYNCH release set.
- R10: Any command written outside IDLE, apart from a clear in DONE, is ignored: the line number and the state are unchanged.
- R11: A rising edge of a line's remote request clears that line's SYNCH release on the next clock. A request that stays high does not block a later release.
- R12: rx_word holds the last received word through send transfers and line-load commands.
- R13: The status byte is {ready, busy, selected line's SYNCH release, 0, line number}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command write strobe, one cycle |
| cmd_data | input | 8 | Command byte |
| tx_word | input | 8 | Word to send, taken when a send is accepted |
| link_data_in | input | 16 | DATA level seen on each line |
| link_sync_in | input | 16 | Wired-AND SYNCH level seen on each line |
| link_req_out | input | 16 | Request output of each remote endpoint |
| link_data_out | output | 16 | DATA driven onto each line |
| link_data_oe | output | 16 | DATA output enable per line |
| link_sync_rel | output | 16 | 1 = hub releases that line's SYNCH |
| rx_word | output | 8 | Last received word |
| status | output | 8 | Status byte |
| state_code | output | 3 | Controller state code |
| irq | output | 1 | Transfer complete interrupt |

## Verification
The assertions check on every cycle that the following hold:
- At most one DATA output is enabled.
- The line number stays stable outside IDLE.
- The bit position moves only on a shift.
- DONE holds without a clear, and END always returns to IDLE.
- A request edge always leaves its line clamped.

Only the bench scenarios can show the rest:
- The bit order on the wire.
- Stalls in the middle of a word.
- The keep and normal clear paths.
- Send winning over receive.
- rx_word surviving later sends.
- The release being set again under a request that stays high.

Each of these is compared with expected values that the bench computes from random words, random lines and random stall lengths.

// File: rtl/xmh_pkg.sv
package xmh_pkg;
    localparam int CMD_W    = 8;
    localparam int CMD_RX   = 4;
    localparam int CMD_TX   = 5;
    localparam int CMD_KEEP = 6;
    localparam int CMD_CLR  = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'b000,
        ST_WRITE = 3'b001,
        ST_READ  = 3'b110,
        ST_DONE  = 3'b100,
        ST_END   = 3'b011
    } xmh_state_e;
endpackage

// File: rtl/xmh_ctrl.sv
module xmh_ctrl
    import xmh_pkg::*;
#(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              sel_sync,
    input  logic              last_bit,
    output xmh_state_e        state_o,
    output logic [LINE_W-1:0] line_o,
    output logic              start_o,
    output logic              is_tx_o,
    output logic              shift_o,
    output logic              commit_o,
    output logic              set_o,
    output logic [LINE_W-1:0] set_line_o,
    output logic              clr_o
);
    xmh_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic              keep_q;
    logic              want_xfer, accept, load_only, clear_cmd;

    assign want_xfer = cmd_data[CMD_TX] | cmd_data[CMD_RX];
    assign accept    = (state_q == ST_IDLE) && cmd_wr && want_xfer;
    assign load_only = (state_q == ST_IDLE) && cmd_wr && !want_xfer;
    assign clear_cmd = cmd_wr && cmd_data[CMD_CLR];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = cmd_data[CMD_TX] ? ST_WRITE : ST_READ;
            ST_WRITE: if (sel_sync && last_bit) state_d = ST_DONE;
            ST_READ:  if (sel_sync && last_bit) state_d = ST_DONE;
            ST_DONE:  if (clear_cmd) state_d = keep_q ? ST_IDLE : ST_END;
            ST_END:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            keep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept || load_only) line_q <= cmd_data[LINE_W-1:0];
            if (accept) keep_q <= cmd_data[CMD_KEEP];
        end
    end

    always_comb begin
        state_o    = state_q;
        line_o     = line_q;
        start_o    = accept;
        is_tx_o    = cmd_data[CMD_TX];
        set_o      = accept;
        set_line_o = cmd_data[LINE_W-1:0];
        clr_o      = (state_q == ST_END);
        shift_o    = ((state_q == ST_WRITE) || (state_q == ST_READ)) && sel_sync;
        commit_o   = (state_q == ST_READ) && sel_sync && last_bit;
    end

    // R10
    line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(line_q));
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !clear_cmd) |=> (state_q == ST_DONE));
    // R8
    end_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/xmh_shifter.sv
module xmh_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift,
    input  logic              in_bit,
    input  logic              commit,
    output logic              out_bit,
    output logic              last_bit,
    output logic [WORD_W-1:0] rx_word
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] sreg_q, rx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sreg_next;

    assign sreg_next = {sreg_q[WORD_W-2:0], in_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
            rx_q   <= '0;
        end else begin
            if (start) begin
                sreg_q <= load_val;
                cnt_q  <= '0;
            end else if (shift) begin
                sreg_q <= sreg_next;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (commit) rx_q <= sreg_next;
        end
    end

    assign out_bit  = sreg_q[WORD_W-1];
    assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));
    assign rx_word  = rx_q;

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !start) |=> $stable(cnt_q));
    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !start) |=> $stable(out_bit));
endmodule

// File: rtl/xmh_line_route.sv
module xmh_line_route #(
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = 4
) (
    input  logic [LINE_W-1:0]    line,
    input  logic [NUM_LINES-1:0] data_in,
    input  logic [NUM_LINES-1:0] sync_in,
    input  logic [NUM_LINES-1:0] sync_rel,
    input  logic                 tx_bit,
    input  logic                 tx_active,
    input  logic                 set,
    input  logic [LINE_W-1:0]    set_line,
    input  logic                 clr,
    output logic [NUM_LINES-1:0] data_out,
    output logic [NUM_LINES-1:0] data_oe,
    output logic                 sel_data,
    output logic                 sel_sync,
    output logic [NUM_LINES-1:0] set_vec,
    output logic [NUM_LINES-1:0] clr_vec
);
    assign sel_data = data_in[line];
    assign sel_sync = sync_in[line] & sync_rel[line];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_demux
        logic hit;
        assign hit        = (line == LINE_W'(i));
        assign data_oe[i] = tx_active & hit;
        assign data_out[i]= tx_active & hit & tx_bit;
        assign set_vec[i] = set & (set_line == LINE_W'(i));
        assign clr_vec[i] = clr & hit;
    end
endmodule

// File: rtl/xmh_sync_bank.sv
module xmh_sync_bank #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] clr_vec,
    input  logic [NUM_LINES-1:0] req_out,
    output logic [NUM_LINES-1:0] sync_rel
);
    logic [NUM_LINES-1:0] req_prev_q, clamp;

    assign clamp = req_out & ~req_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev_q <= '0;
        else        req_prev_q <= req_out;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_flop
        logic rel_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     rel_q <= 1'b0;
            else if (clamp[i] || clr_vec[i]) rel_q <= 1'b0;
            else if (set_vec[i])            rel_q <= 1'b1;
        end
        assign sync_rel[i] = rel_q;
    end

    // R11
    clamp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clamp) |=> ((sync_rel & $past(clamp)) == '0));
endmodule

// File: rtl/xcvr_mux_hub.sv
module xcvr_mux_hub
    import xmh_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int WORD_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_data,
    input  logic [WORD_W-1:0]    tx_word,
    input  logic [NUM_LINES-1:0] link_data_in,
    input  logic [NUM_LINES-1:0] link_sync_in,
    input  logic [NUM_LINES-1:0] link_req_out,
    output logic [NUM_LINES-1:0] link_data_out,
    output logic [NUM_LINES-1:0] link_data_oe,
    output logic [NUM_LINES-1:0] link_sync_rel,
    output logic [WORD_W-1:0]    rx_word,
    output logic [7:0]           status,
    output logic [2:0]           state_code,
    output logic                 irq
);
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    xmh_state_e           state;
    logic [LINE_W-1:0]    line, set_line;
    logic                 start, is_tx, shift, commit, set, clr;
    logic                 sel_sync, sel_data, last_bit, out_bit;
    logic [NUM_LINES-1:0] set_vec, clr_vec;

    xmh_ctrl #(.LINE_W(LINE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .sel_sync(sel_sync), .last_bit(last_bit), .state_o(state), .line_o(line),
        .start_o(start), .is_tx_o(is_tx), .shift_o(shift), .commit_o(commit),
        .set_o(set), .set_line_o(set_line), .clr_o(clr)
    );

    xmh_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_val(is_tx ? tx_word : '0), .shift(shift), .in_bit(sel_data),
        .commit(commit), .out_bit(out_bit), .last_bit(last_bit), .rx_word(rx_word)
    );

    xmh_line_route #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_route (
        .line(line), .data_in(link_data_in), .sync_in(link_sync_in),
        .sync_rel(link_sync_rel), .tx_bit(out_bit), .tx_active(state == ST_WRITE),
        .set(set), .set_line(set_line), .clr(clr), .data_out(link_data_out),
        .data_oe(link_data_oe), .sel_data(sel_data), .sel_sync(sel_sync),
        .set_vec(set_vec), .clr_vec(clr_vec)
    );

    xmh_sync_bank #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .req_out(link_req_out), .sync_rel(link_sync_rel)
    );

    assign state_code = state;
    assign irq        = (state == ST_DONE);
    assign status     = {state == ST_DONE, state != ST_IDLE, link_sync_rel[line],
                         1'b0, 4'(line)};

    // R4
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_data_oe));
    // R4
    drive_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_data_oe & ~link_sync_rel) == '0) || $past(|link_req_out));
endmodule

// File: tb/xcvr_mux_hub_test.sv
`timescale 1ns/1ps
module xcvr_mux_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic [7:0]  tx_word = '0;
    logic [15:0] link_data_in = '0;
    logic [15:0] link_sync_in = '0;
    logic [15:0] link_req_out = '0;
    logic [15:0] link_data_out, link_data_oe, link_sync_rel;
    logic [7:0]  rx_word, status;
    logic [2:0]  state_code;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    logic [15:0] model_rel = '0;
    logic [7:0]  model_rx = '0;

    xcvr_mux_hub uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .tx_word(tx_word), .link_data_in(link_data_in), .link_sync_in(link_sync_in),
        .link_req_out(link_req_out), .link_data_out(link_data_out),
        .link_data_oe(link_data_oe), .link_sync_rel(link_sync_rel),
        .rx_word(rx_word), .status(status), .state_code(state_code), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R7 watchdog: run hung, actual=busy expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [7:0] exp_status(input logic rdy, input logic busy,
                                              input logic rel, input int ln);
        return {rdy, busy, rel, 1'b0, 4'(ln)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [7:0] c);
        cmd_data = c;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // send or receive one word with random stalls; ends in DONE
    task automatic xfer(input int ln, input bit tx, input logic [7:0] w,
                        input bit keep, input int maxgap, input bit poke);
        tx_word = tx ? w : ~w;
        do_cmd({1'b0, keep, tx, ~tx, 4'(ln)});
        model_rel[ln] = 1'b1;
        chk("R2 busy code", 32'(state_code), tx ? 32'h1 : 32'h6);
        chk("R4 release set", 32'(link_sync_rel), 32'(model_rel));
        for (int k = 0; k < 8; k++) begin
            int gaps;
            gaps = (maxgap > 0) ? int'($urandom_range(maxgap, 0)) : 0;
            for (int g = 0; g < gaps; g++) begin
                link_sync_in[ln] = 1'b0;
                link_data_in[ln] = ~w[7-k];
                if (tx) chk("R6 held bit", 32'(link_data_out[ln]), 32'(w[7-k]));
                if (poke && g == 0) begin
                    do_cmd({1'b0, 1'b0, 1'b0, 1'b1, 4'(ln ^ 5)});
                    chk("R10 line kept", 32'(status[3:0]), 32'(ln));
                end else begin
                    @(negedge clk);
                end
                chk("R6 still busy", 32'(state_code), tx ? 32'h1 : 32'h6);
            end
            link_sync_in[ln] = 1'b1;
            link_data_in[ln] = w[7-k];
            if (tx) begin
                chk("R4 msb-first bit", 32'(link_data_out[ln]), 32'(w[7-k]));
                chk("R4 single oe", 32'(link_data_oe), 32'(16'h1 << ln));
            end
            @(negedge clk);
        end
        link_sync_in[ln] = 1'b0;
        if (!tx) model_rx = w;
        chk("R7 done code", 32'(state_code), 32'h4);
        chk("R13 ready status", 32'(status), 32'(exp_status(1, 1, 1, ln)));
        chk("R7 irq", 32'(irq), 32'h1);
        chk(tx ? "R12 rx kept" : "R5 rx word", 32'(rx_word), 32'(model_rx));
    endtask

    task automatic finish_xfer(input int ln, input bit keep);
        do_cmd(8'h80);
        if (keep) begin
            chk("R9 idle", 32'(state_code), 32'h0);
            chk("R9 release kept", 32'(link_sync_rel), 32'(model_rel));
        end else begin
            chk("R8 end code", 32'(state_code), 32'h3);
            @(negedge clk);
            model_rel[ln] = 1'b0;
            chk("R8 idle", 32'(state_code), 32'h0);
            chk("R8 release dropped", 32'(link_sync_rel), 32'(model_rel));
        end
    endtask

    initial begin
        void'($urandom(32'd1977));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", 32'(state_code), 32'h0);
        chk("R1 release", 32'(link_sync_rel), 32'h0);
        chk("R1 oe", 32'(link_data_oe), 32'h0);
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 rx", 32'(rx_word), 32'h0);

        // R3 line-load only
        do_cmd(8'h0B);
        chk("R3 load idle", 32'(state_code), 32'h0);
        chk("R3 load line", 32'(status), 32'(exp_status(0, 0, 0, 11)));

        // directed corners
        xfer(0, 0, 8'h80, 0, 0, 0);
        finish_xfer(0, 0);
        xfer(15, 1, 8'h01, 0, 2, 0);
        finish_xfer(15, 0);
        xfer(7, 0, 8'hFF, 0, 3, 1);
        // DONE ignores non-clear command
        do_cmd(8'h32);
        chk("R10 done held", 32'(state_code), 32'h4);
        chk("R10 done line", 32'(status[3:0]), 32'h7);
        finish_xfer(7, 0);

        // R3 send wins over receive
        tx_word = 8'hA5;
        do_cmd(8'h34);
        model_rel[4] = 1'b1;
        chk("R3 send wins", 32'(state_code), 32'h1);
        for (int k = 0; k < 8; k++) begin
            link_sync_in[4] = 1'b1;
            chk("R3 send bit", 32'(link_data_out[4]), 32'(tx_word[7-k]));
            @(negedge clk);
        end
        link_sync_in[4] = 1'b0;
        finish_xfer(4, 0);
        chk("R12 rx after send", 32'(rx_word), 32'(model_rx));

        // R9 keep mode then R11 clamp
        xfer(5, 0, 8'h3C, 1, 1, 0);
        finish_xfer(5, 1);
        link_req_out[5] = 1'b1;
        @(negedge clk);
        model_rel[5] = 1'b0;
        chk("R11 clamp", 32'(link_sync_rel), 32'(model_rel));
        xfer(5, 1, 8'h00, 0, 1, 0);
        chk("R11 steady req no clamp", 32'(link_sync_rel[5]), 32'h1);
        finish_xfer(5, 0);
        link_req_out[5] = 1'b0;

        // random mix
        for (int it = 0; it < 40; it++) begin
            int ln;
            bit tx, keep;
            logic [7:0] w;
            ln = int'($urandom_range(15, 0));
            tx = 1'($urandom());
            keep = 1'($urandom());
            w = 8'($urandom());
            xfer(ln, tx, w, keep, 3, (it % 5) == 0);
            finish_xfer(ln, keep);
            if (keep && ((it % 3) == 0)) begin
                link_req_out[ln] = 1'b1;
                @(negedge clk);
                model_rel[ln] = 1'b0;
                chk("R11 clamp random", 32'(link_sync_rel), 32'(model_rel));
                link_req_out[ln] = 1'b0;
                @(negedge clk);
            end
            if ((it % 7) == 0) begin
                do_cmd(8'(ln ^ 3));
                chk("R12 rx after load", 32'(rx_word), 32'(model_rx));
                chk("R3 load random", 32'(status[3:0]), 32'(ln ^ 3));
            end
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule